// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This unit handles the conditional test instructions of a small 16-bit processor. Each cycle the execute stage may issue an opcode with the two operand values it has already fetched, plus the instruction word that follows in memory. When the opcode is one of the seven relation tests and the relation does not hold, the unit signals a skip one cycle later. Along with the skip it gives the number of words the program counter must move to get past the whole following instruction, including any extra operand words that instruction carries. When the test holds, or the opcode is not a test, nothing is skipped and the advance is zero.

The control is a two-state machine. `ST_IDLE` means no skip is being signalled. `ST_SKIP` means a skip is being signalled this cycle. The transitions are as follows. `IDLE->SKIP` happens on a failing test. `SKIP->SKIP` happens when another failing test arrives in the cycle the skip is shown. `SKIP->IDLE` and `IDLE->IDLE` happen on any other input.

Top module: `cskip_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `skip_now` is 0 and `pc_advance` is 0.
- R2: Opcode 0x11 passes when `opnd_first & opnd_second` is nonzero and fails otherwise.
- R3: Opcode 0x12 passes only when the two operands are equal.
- R4: Opcode 0x13 passes only when the two operands differ.
- R5: Opcode 0x14 passes only when `opnd_first` > `opnd_second` as signed two's-complement values.
- R6: Opcode 0x15 passes only when `opnd_first` > `opnd_second` as unsigned values.
- R7: Opcode 0x16 passes only on a signed `opnd_first` < `opnd_second`. Opcode 0x17 passes only on an unsigned `opnd_first` < `opnd_second`.
- R8: An opcode outside 0x11..0x17, or any cycle with `issue_valid` low, never produces a skip. `pc_advance` stays 0 in that case.
- R9: A passing test gives `skip_now` = 0 and `pc_advance` = 0 in the following cycle.
- R10: A failing test sampled at a rising edge raises `skip_now` for the one cycle after that edge. In that cycle `pc_advance` = 1 plus the number of operand fields of `follow_word` that need an extra word. The fields are: opcode in bits [4:0], destination field in bits [9:5], source field in bits [15:10]. A field needs an extra word when its value is 0x10–0x17, 0x1a, 0x1e or 0x1f. Source values 0x20–0x3f are inline literals and need no word.
- R11: When `follow_word[4:0]` is 0, the destination field holds a sub-opcode and is not counted. Only the source field can add a word.
- R12: Failing tests in back-to-back cycles keep `skip_now` high in each following cycle. Each cycle carries the advance of its own `follow_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_opcode | input | 5 | Opcode of the presented instruction |
| opnd_first | input | 16 | First operand value |
| opnd_second | input | 16 | Second operand value |
| follow_word | input | 16 | First word of the next instruction |
| skip_now | output | 1 | Skip the next instruction (registered) |
| pc_advance | output | 2 | Words to step past when skipping, else 0 |

## Verification
Both results come from a single register stage. The inputs sampled at one rising edge show up on `skip_now` and `pc_advance` just after that edge, and they hold only until the next edge. The bench drives its inputs on the falling edge. It reads the outputs on the next falling edge, halfway through the cycle in which they are due. It then drops `issue_valid`, so the cycle after a skip also shows the return to idle. For back-to-back cases it reads each cycle in turn and compares it with the word issued one edge earlier.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
    localparam int DATA_W = 16;
    localparam int OPC_W  = 5;
    localparam int ADV_W  = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_BITS  = 5'h11,
        OPC_EQ    = 5'h12,
        OPC_NE    = 5'h13,
        OPC_SGT   = 5'h14,
        OPC_UGT   = 5'h15,
        OPC_SLT   = 5'h16,
        OPC_ULT   = 5'h17
    } cond_opc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SKIP = 1'b1
    } skip_state_e;
endpackage

// File: rtl/cskip_relation.sv
module cskip_relation
    import cskip_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     lhs,
    input  logic [W-1:0]     rhs,
    output logic             is_cond,
    output logic             holds
);
    logic s_gt, s_lt, u_gt, u_lt;

    always_comb begin
        s_gt = $signed(lhs) > $signed(rhs);
        s_lt = $signed(lhs) < $signed(rhs);
        u_gt = lhs > rhs;
        u_lt = lhs < rhs;
        is_cond = 1'b1;
        holds   = 1'b0;
        case (opcode)
            OPC_BITS: holds = |(lhs & rhs);
            OPC_EQ:   holds = (lhs == rhs);
            OPC_NE:   holds = (lhs != rhs);
            OPC_SGT:  holds = s_gt;
            OPC_UGT:  holds = u_gt;
            OPC_SLT:  holds = s_lt;
            OPC_ULT:  holds = u_lt;
            default: begin
                is_cond = 1'b0;
                holds   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cskip_length.sv
module cskip_length
    import cskip_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int DST_LO = 5,
    parameter int DST_W  = 5,
    parameter int SRC_LO = 10,
    parameter int SRC_W  = 6
) (
    input  logic [W-1:0]     word,
    output logic [ADV_W-1:0] length
);
    localparam int NFIELD = 2;
    localparam int FMAX   = (SRC_W > DST_W) ? SRC_W : DST_W;

    logic [NFIELD-1:0] extra;
    logic              special;

    assign special = (word[OPC_W-1:0] == '0);

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        localparam int LO = (f == 0) ? DST_LO : SRC_LO;
        localparam int FW = (f == 0) ? DST_W  : SRC_W;
        logic [FMAX-1:0] val;
        logic            wants;
        always_comb begin
            val = '0;
            val[FW-1:0] = word[LO +: FW];
            wants = ((val >= FMAX'(6'h10)) && (val <= FMAX'(6'h17)))
                 || (val == FMAX'(6'h1a))
                 || (val == FMAX'(6'h1e))
                 || (val == FMAX'(6'h1f));
        end
        if (f == 0) begin : g_dst
            assign extra[f] = wants && !special;
        end else begin : g_src
            assign extra[f] = wants;
        end
    end

    assign length = ADV_W'(1) + ADV_W'(extra[0]) + ADV_W'(extra[1]);
endmodule

// File: rtl/cskip_unit.sv
module cskip_unit
    import cskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [4:0]        issue_opcode,
    input  logic [15:0]       opnd_first,
    input  logic [15:0]       opnd_second,
    input  logic [15:0]       follow_word,
    output logic              skip_now,
    output logic [1:0]        pc_advance
);
    skip_state_e       state_q, state_d;
    logic              is_cond, holds, fail;
    logic [ADV_W-1:0]  len, adv_q;

    cskip_relation #(.W(DATA_W)) u_rel (
        .opcode  (issue_opcode),
        .lhs     (opnd_first),
        .rhs     (opnd_second),
        .is_cond (is_cond),
        .holds   (holds)
    );

    cskip_length #(.W(DATA_W)) u_len (
        .word   (follow_word),
        .length (len)
    );

    assign fail = issue_valid && is_cond && !holds;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = fail ? ST_SKIP : ST_IDLE;
            ST_SKIP: state_d = fail ? ST_SKIP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            adv_q   <= '0;
        end else begin
            state_q <= state_d;
            adv_q   <= fail ? len : '0;
        end
    end

    always_comb begin
        skip_now   = 1'b0;
        pc_advance = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SKIP: begin
                skip_now   = 1'b1;
                pc_advance = adv_q;
            end
            default: ;
        endcase
    end

    // R1: outputs are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!skip_now && pc_advance == '0));

    // R8: a skip needs a valid conditional opcode on the previous edge
    p_skip_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_now |-> $past(issue_valid && issue_opcode >= 5'h11 && issue_opcode <= 5'h17));

    // R9: no advance without a skip
    p_no_adv_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_now |-> (pc_advance == '0));

    // R10: a skip always advances by one to three words
    p_adv_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_now |-> (pc_advance != '0));

    // R3: equal operands on the equality test never skip
    p_eq_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_opcode == 5'h12 && opnd_first == opnd_second) |=> !skip_now);
endmodule

// File: tb/tb_cskip_unit.sv
module tb_cskip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [4:0]  issue_opcode = '0;
    logic [15:0] opnd_first = '0, opnd_second = '0, follow_word = '0;
    logic        skip_now;
    logic [1:0]  pc_advance;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cskip_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_opcode(issue_opcode), .opnd_first(opnd_first),
        .opnd_second(opnd_second), .follow_word(follow_word),
        .skip_now(skip_now), .pc_advance(pc_advance)
    );

    function automatic bit fld_word(input int v);
        return (v >= 16 && v <= 23) || v == 26 || v == 30 || v == 31;
    endfunction

    function automatic int exp_len(input logic [15:0] w);
        int n = 1;
        if (w[4:0] != 0 && fld_word(int'(w[9:5]))) n++;
        if (fld_word(int'(w[15:10]))) n++;
        return n;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // issue one instruction, read the registered result one edge later
    task automatic issue(input string req, input logic [4:0] opc,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] w, input bit exp_skip);
        @(negedge clk);
        issue_valid = 1'b1; issue_opcode = opc;
        opnd_first = a; opnd_second = b; follow_word = w;
        @(negedge clk);
        issue_valid = 1'b0;
        check(req, int'(skip_now), int'(exp_skip));
        check(req, int'(pc_advance), exp_skip ? exp_len(w) : 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", int'(skip_now), 0);
        check("R1", int'(pc_advance), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(skip_now), 0);
    endtask

    task automatic t_relations();
        issue("R2", 5'h11, 16'h00f0, 16'h0010, 16'h0001, 1'b0);
        issue("R2", 5'h11, 16'h00f0, 16'h0f00, 16'h0001, 1'b1);
        issue("R3", 5'h12, 16'h1234, 16'h1234, 16'h0001, 1'b0);
        issue("R3", 5'h12, 16'h1234, 16'h1235, 16'h0001, 1'b1);
        issue("R4", 5'h13, 16'h0007, 16'h0008, 16'h0001, 1'b0);
        issue("R4", 5'h13, 16'h0007, 16'h0007, 16'h0001, 1'b1);
        issue("R5", 5'h14, 16'h0001, 16'hffff, 16'h0001, 1'b0);
        issue("R5", 5'h14, 16'hffff, 16'h0001, 16'h0001, 1'b1);
        issue("R5", 5'h14, 16'h0005, 16'h0005, 16'h0001, 1'b1);
        issue("R6", 5'h15, 16'hffff, 16'h0001, 16'h0001, 1'b0);
        issue("R6", 5'h15, 16'h0001, 16'hffff, 16'h0001, 1'b1);
        issue("R7", 5'h16, 16'h8000, 16'h7fff, 16'h0001, 1'b0);
        issue("R7", 5'h16, 16'h7fff, 16'h8000, 16'h0001, 1'b1);
        issue("R7", 5'h17, 16'h7fff, 16'h8000, 16'h0001, 1'b0);
        issue("R7", 5'h17, 16'h8000, 16'h7fff, 16'h0001, 1'b1);
    endtask

    task automatic t_non_cond();
        issue("R8", 5'h10, 16'h0000, 16'h0000, 16'hfbe1, 1'b0);
        issue("R8", 5'h18, 16'h0000, 16'h0001, 16'hfbe1, 1'b0);
        @(negedge clk);
        issue_valid = 1'b0; issue_opcode = 5'h12;
        opnd_first = 16'h1; opnd_second = 16'h2;
        @(negedge clk);
        check("R8", int'(skip_now), 0);
        check("R8", int'(pc_advance), 0);
    endtask

    task automatic t_lengths();
        // R9: passing test with a three-word follower still advances 0
        issue("R9", 5'h12, 16'h0, 16'h0, {6'h1f, 5'h1e, 5'h01}, 1'b0);
        // R10: field combinations
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h1f, 5'h1e, 5'h01}, 1'b1);
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h10, 5'h00, 5'h02}, 1'b1);
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h00, 5'h17, 5'h02}, 1'b1);
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h1a, 5'h1b, 5'h02}, 1'b1);
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h3f, 5'h0f, 5'h02}, 1'b1);
        issue("R10", 5'h12, 16'h0, 16'h1, {6'h30, 5'h18, 5'h02}, 1'b1);
        // R11: sub-opcode field not counted
        issue("R11", 5'h12, 16'h0, 16'h1, {6'h1e, 5'h1f, 5'h00}, 1'b1);
        issue("R11", 5'h12, 16'h0, 16'h1, {6'h21, 5'h10, 5'h00}, 1'b1);
    endtask

    task automatic t_back_to_back();
        logic [15:0] w1 = {6'h1f, 5'h1e, 5'h01};
        logic [15:0] w2 = {6'h00, 5'h00, 5'h01};
        @(negedge clk);
        issue_valid = 1'b1; issue_opcode = 5'h13;
        opnd_first = 16'h9; opnd_second = 16'h9; follow_word = w1;
        @(negedge clk);
        check("R12", int'(skip_now), 1);
        check("R12", int'(pc_advance), exp_len(w1));
        issue_opcode = 5'h17; opnd_first = 16'h9; opnd_second = 16'h3;
        follow_word = w2;
        @(negedge clk);
        issue_valid = 1'b0;
        check("R12", int'(skip_now), 1);
        check("R12", int'(pc_advance), exp_len(w2));
        @(negedge clk);
        check("R10", int'(skip_now), 0);
        check("R10", int'(pc_advance), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_relations();
                t_non_cond();
                t_lengths();
                t_back_to_back();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule